// File: doc/BRIEF.md
# Eight-Character Display Buffer

This block stores one line of eight ASCII characters for a small character display. A host reaches it over a simple register bus: a 3-bit byte address, a 2-bit access size (1, 2, 4 or 8 bytes), 64-bit write data and 64-bit read data. An access may start at any byte offset. Its byte lanes walk forward through the line and wrap from the last character back to the first.

Every write asks a built-in streamer to re-send the whole line to the display over a byte-wide valid/ready link. A line is sent as a carriage return followed by the eight characters. The streamer copies the line when it starts sending, so each line it sends is consistent. After reset the streamer first sends a single blank character, once, to wake the display.

Top module: `disp_line_buf`

## Requirements
- R1: After reset all eight entries hold the space code 0x20 and `rdata_o` is zero.
- R2: The access size is encoded as `size_i` 0, 1, 2 and 3 for 1, 2, 4 and 8 bytes. A write stores bits [8k+7:8k] of `wdata_i` into entry (addr + k) mod 8 for each lane k below the size. Other entries keep their contents.
- R3: `rdata_o` is valid in the cycle after `rd_en_i`. Lane k sits in bits [8k+7:8k] and holds entry (addr + k) mod 8.
- R4: Read-data bytes at lanes at or above the access size are zero. `rdata_o` is all zero in the cycle after a cycle with no read.
- R5: For reads and writes, an access whose lanes run past entry 7 continues at entry 0.
- R6: A write starts a line frame on the display port: the byte 0x0D, then entries 0 through 7 in order. The frame carries the contents the line had when the frame began.
- R7: A write that arrives while a frame is being sent leaves a pending refresh, and exactly one more frame follows the current one. Several writes during one frame still give only one extra frame.
- R8: After reset the display port first presents one byte 0x20. It stays presented until accepted, goes out before any frame, and is not repeated.
- R9: While `disp_valid_o` is high and `disp_ready_i` is low, `disp_valid_o` stays high and `disp_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| addr_i | input | 3 | Starting byte offset |
| size_i | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:8B) |
| wdata_i | input | 64 | Write data, lane 0 in the low byte |
| rdata_o | output | 64 | Read data, one cycle after the read |
| disp_valid_o | output | 1 | Display byte valid |
| disp_data_o | output | 8 | Display byte |
| disp_ready_i | input | 1 | Display accepts the byte |

## Verification
The line is written with every access size, at an aligned offset and at offsets that wrap past entry 7. Readback at a different size and offset from the write then separates a wrong lane order from a wrong wrap point, and catches upper bytes that should be zero. The frame stream is checked byte by byte in three settings: with the display always ready, with ready driven by a pseudo-random pattern, and with writes issued in the middle of a frame. These cases separate a lost pending refresh from a duplicated frame, and a frame that is copied at its start from one that reads the live line. Holding ready low right after reset shows that the one-time blank is presented first and is waiting to be accepted.

// File: rtl/disp_line_pkg.sv
package disp_line_pkg;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_CR    = 8'h0D;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;
endpackage

// File: rtl/disp_line_store.sv
module disp_line_store
  import disp_line_pkg::*;
#(
  parameter int N_CHARS = 8,
  localparam int AW = $clog2(N_CHARS),
  localparam int DW = 8 * N_CHARS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] line_o
);
  logic [7:0]    chars_q [N_CHARS];
  logic [AW:0]   n_bytes;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] rdata_q;

  assign n_bytes = (AW+1)'(1) << size_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_CHARS; k++) chars_q[k] <= CH_SPACE;
    end else if (wr_en_i) begin
      for (int k = 0; k < N_CHARS; k++) begin
        if ((AW+1)'(k) < n_bytes) chars_q[addr_i + AW'(k)] <= wdata_i[8*k +: 8];
      end
    end
  end

  // lane k reads entry (addr + k) mod N_CHARS; lanes beyond the size read zero
  for (genvar k = 0; k < N_CHARS; k++) begin : g_lane
    assign rd_word[8*k +: 8] = ((AW+1)'(k) < n_bytes) ? chars_q[addr_i + AW'(k)] : 8'h00;
    assign line_o[8*k +: 8]  = chars_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en_i ? rd_word : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/disp_line_stream.sv
module disp_line_stream
  import disp_line_pkg::*;
#(
  parameter int N_CHARS = 8,
  localparam int AW = $clog2(N_CHARS),
  localparam int CW = $clog2(N_CHARS + 1),
  localparam int DW = 8 * N_CHARS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          refresh_i,
  input  logic [DW-1:0] line_i,
  output logic          valid_o,
  output logic [7:0]    data_o,
  input  logic          ready_i
);
  logic          init_pend_q, busy_q, pend_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] snap_q;
  logic [7:0]    snap_b [N_CHARS];
  logic [AW-1:0] sel;
  logic          hs, start;

  for (genvar k = 0; k < N_CHARS; k++) begin : g_unpack
    assign snap_b[k] = snap_q[8*k +: 8];
  end

  assign hs    = valid_o & ready_i;
  assign start = !busy_q && !init_pend_q && pend_q;
  assign sel   = AW'(cnt_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_pend_q <= 1'b1;
      busy_q      <= 1'b0;
      pend_q      <= 1'b0;
      cnt_q       <= '0;
      snap_q      <= {N_CHARS{CH_SPACE}};
    end else begin
      if (init_pend_q && hs) init_pend_q <= 1'b0;
      // a write in the start cycle keeps the request pending
      if (refresh_i)  pend_q <= 1'b1;
      else if (start) pend_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        snap_q <= line_i;
      end else if (busy_q && hs) begin
        if (cnt_q == CW'(N_CHARS)) busy_q <= 1'b0;
        else                       cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  assign valid_o = init_pend_q | busy_q;
  assign data_o  = init_pend_q       ? CH_SPACE :
                   (cnt_q == '0)     ? CH_CR    : snap_b[sel];
endmodule

// File: rtl/disp_line_buf.sv
module disp_line_buf
  import disp_line_pkg::*;
#(
  parameter int N_CHARS = 8,
  localparam int AW = $clog2(N_CHARS),
  localparam int DW = 8 * N_CHARS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          disp_valid_o,
  output logic [7:0]    disp_data_o,
  input  logic          disp_ready_i
);
  logic [DW-1:0] line;

  disp_line_store #(.N_CHARS(N_CHARS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .size_i  (size_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .line_o  (line)
  );

  disp_line_stream #(.N_CHARS(N_CHARS)) u_stream (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .refresh_i (wr_en_i),
    .line_i    (line),
    .valid_o   (disp_valid_o),
    .data_o    (disp_data_o),
    .ready_i   (disp_ready_i)
  );
endmodule

// File: rtl/disp_line_buf_chk.sv
module disp_line_buf_chk #(
  parameter int DW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_en_i,
  input logic [1:0]    size_i,
  input logic [DW-1:0] rdata_o,
  input logic          disp_valid_o,
  input logic [7:0]    disp_data_o,
  input logic          disp_ready_i
);
  logic seen_hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          seen_hs_q <= 1'b0;
    else if (disp_valid_o && disp_ready_i) seen_hs_q <= 1'b1;
  end

  p_valid_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && !disp_ready_i |=> disp_valid_o);

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && !disp_ready_i |=> $stable(disp_data_o));

  p_upper_zero_1b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && size_i == 2'd0 |=> rdata_o[DW-1:8] == '0);

  p_upper_zero_2b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && size_i == 2'd1 |=> rdata_o[DW-1:16] == '0);

  p_upper_zero_4b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && size_i == 2'd2 |=> rdata_o[DW-1:32] == '0);

  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0);

  p_first_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_hs_q && disp_valid_o |-> disp_data_o == 8'h20);
endmodule

bind disp_line_buf disp_line_buf_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_en_i      (rd_en_i),
  .size_i       (size_i),
  .rdata_o      (rdata_o),
  .disp_valid_o (disp_valid_o),
  .disp_data_o  (disp_data_o),
  .disp_ready_i (disp_ready_i)
);

// File: tb/disp_line_buf_tb_top.sv
`timescale 1ns/1ps
module disp_line_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        disp_valid, disp_ready;
  logic [7:0]  disp_data;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  bit  rdy_en = 1'b0, rdy_rand = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  logic [7:0] m [8];
  logic [7:0] exp_q [$];

  always #2 clk = ~clk;

  disp_line_buf dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .disp_valid_o(disp_valid), .disp_data_o(disp_data), .disp_ready_i(disp_ready)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [63:0] model_rd(logic [2:0] a, logic [1:0] s);
    logic [63:0] r = '0;
    for (int k = 0; k < (1 << s); k++) r[8*k +: 8] = m[(a + k) % 8];
    return r;
  endfunction

  // ready: held low until enabled, then always high or pseudo-random
  initial begin
    disp_ready = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      disp_ready = rdy_en & (!rdy_rand | lfsr[0]);
    end
  end

  // monitor: compares each accepted display byte with the scoreboard (R6 R7 R8)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_ni && disp_valid && disp_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R6/R8 unexpected display byte", 64'(disp_data), 64'hx);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(disp_data == e, "R6 display byte", 64'(disp_data), 64'(e));
        end
      end
    end
  end

  task automatic do_wr(logic [2:0] a, logic [1:0] s, logic [63:0] d, bit push);
    @(negedge clk);
    wr_en = 1'b1; addr = a; size = s; wdata = d;
    for (int k = 0; k < (1 << s); k++) m[(a + k) % 8] = d[8*k +: 8];
    if (push) begin
      exp_q.push_back(8'h0D);
      for (int k = 0; k < 8; k++) exp_q.push_back(m[k]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(logic [2:0] a, logic [1:0] s, string req);
    logic [63:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a; size = s;
    e = model_rd(a, s);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rdata == e, req, rdata, e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h0);
    finish_sim();
  end

  initial begin
    for (int k = 0; k < 8; k++) m[k] = 8'h20;
    repeat (3) @(negedge clk);
    chk(rdata == 64'h0, "R1 rdata in reset", rdata, 64'h0);
    rst_ni = 1'b1;
    exp_q.push_back(8'h20);
    repeat (4) @(negedge clk);
    // R8: blank presented and held while ready is low
    chk(disp_valid == 1'b1, "R8 init valid", 64'(disp_valid), 64'h1);
    chk(disp_data == 8'h20, "R8 init byte", 64'(disp_data), 64'h20);
    chk(rdata == 64'h0, "R1 rdata after reset", rdata, 64'h0);
    do_rd(3'd0, 2'd3, "R1 reset contents");
    @(negedge clk);
    chk(rdata == 64'h0, "R4 rdata zero after idle cycle", rdata, 64'h0);

    // write while the init byte is still waiting: frame follows the blank (R8 R6)
    do_wr(3'd0, 2'd3, 64'h4847_4645_4443_4241, 1'b1);
    rdy_en = 1'b1;
    drain();
    do_rd(3'd0, 2'd3, "R2 R3 8-byte readback");
    do_rd(3'd2, 2'd1, "R3 2-byte read at offset 2");

    do_wr(3'd5, 2'd0, 64'hFFFF_FFFF_FFFF_FF7A, 1'b1);
    drain();
    do_rd(3'd5, 2'd0, "R2 R4 1-byte write/read");
    do_rd(3'd4, 2'd2, "R2 neighbours unchanged");

    do_wr(3'd7, 2'd1, 64'hAAAA_AAAA_AAAA_3231, 1'b1);
    drain();
    do_rd(3'd7, 2'd1, "R5 2-byte wrap read");
    do_rd(3'd0, 2'd0, "R5 wrapped byte in entry 0");

    do_wr(3'd6, 2'd2, 64'h5555_5555_6463_6261, 1'b1);
    drain();
    do_rd(3'd6, 2'd2, "R5 4-byte wrap");
    do_rd(3'd3, 2'd3, "R5 R3 8-byte read at offset 3");
    do_rd(3'd1, 2'd2, "R4 4-byte read upper zero");

    // R9: pseudo-random back-pressure
    rdy_rand = 1'b1;
    do_wr(3'd4, 2'd3, 64'h3837_3635_3433_3231, 1'b1);
    drain();
    do_wr(3'd2, 2'd0, 64'h0000_0000_0000_0021, 1'b1);
    drain();
    do_rd(3'd0, 2'd3, "R9 contents after back-pressure");
    rdy_rand = 1'b0;

    // R7: write during an active frame gives one more frame
    do_wr(3'd0, 2'd3, 64'h6867_6665_6463_6261, 1'b1);
    repeat (2) @(negedge clk);
    do_wr(3'd3, 2'd1, 64'h0000_0000_0000_5958, 1'b1);
    drain();
    // R7: several writes during one frame coalesce into one extra frame
    do_wr(3'd0, 2'd0, 64'h31, 1'b1);
    @(negedge clk);
    do_wr(3'd1, 2'd0, 64'h32, 1'b0);
    do_wr(3'd2, 2'd0, 64'h33, 1'b1);
    drain();
    chk(exp_q.size() == 0, "R7 no missing bytes", 64'(exp_q.size()), 64'h0);
    chk(disp_valid == 1'b0, "R7 R8 stream idle, no repeat", 64'(disp_valid), 64'h0);
    do_rd(3'd0, 2'd3, "R7 final contents");
    finish_sim();
  end
endmodule